// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

A small embedded memory with a 576-bit storage pool, one port that only writes and a second, independent port that only reads. Each port's word width is a parameter, and the two widths may differ. A word written through a narrow port can be read back as part of a wider word, or the reverse, because both ports compute a bit offset into the same storage array.

Plain data widths (1, 2, 4, 8 and 16 bits) share a 512-bit data space. The parity-carrying widths (9 and 18 bits) use the whole 576-bit pool, seen as 64 nine-bit bytes. A width pairing that mixes the two families, or that names an unsupported width, stops elaboration. Writes take effect on the clock edge. The read port has one register stage. Both ports drive an address bus of a fixed width, so an address past the end of the configured depth is possible and is handled explicitly.

Top module: `mwram_top`

## Requirements
- R1: While rst_n is low, rd_data is driven to zero and every storage bit is cleared. After reset is released, any in-range read returns zero until that location has been written.
- R2: When wr_en is high at a rising clock edge and wr_addr is below the write depth (pool bits / WR_W), wr_data is stored at that word. Other words keep their contents.
- R3: Read data is registered. With rd_en high at an edge, rd_data takes the addressed word at that edge and does not change before it.
- R4: With rd_en low at an edge, rd_data keeps its value.
- R5: For plain widths (1, 2, 4, 8, 16), word A of width W occupies bits A*W to A*W+W-1 of a 512-bit space, whatever width the other port uses. For example, 4-bit words 0..3 together make up 16-bit word 0, with word 0 in bits 3:0.
- R6: For widths 9 and 18, the pool is 64 nine-bit bytes. An 18-bit word at address A holds byte 2A in bits 8:0 and byte 2A+1 in bits 17:9. Byte addresses up to 63 and 18-bit addresses up to 31 are usable.
- R7: When a read and a write hit the same bits at the same edge, the read returns the data held before that write.
- R8: A write whose address is at or above the write depth changes no storage bit.
- R9: A read whose address is at or above the read depth loads zero into rd_data.
- R10: A pairing is legal only when both widths come from {1,2,4,8,16}, or both come from {9,18}. Any other pairing is a fatal error at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write word address |
| wr_data | input | WR_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | AW | Read word address |
| rd_data | output | RD_W | Registered read data |

## Verification
A wrong offset calculation in either port shows up as a misplaced slice. The next read that spans the written bits returns it one cycle after the read is issued, usually as a nibble or byte in the wrong lane. An address that wraps past the depth corrupts a low word, so the bench writes just past the end and then reads word 0. A read register that samples the updated storage instead of the old storage is seen on the first same-address read-during-write.

// File: rtl/mwram_pkg.sv
// Shared constants and width rules for the mixed-width RAM.
// Assumes widths are given in bits; no state lives here.
package mwram_pkg;
    localparam int DATA_POOL   = 512;
    localparam int PARITY_POOL = 576;

    // True for the widths that carry a ninth bit per byte
    function automatic bit is_parity_w(input int w);
        return (w == 9) || (w == 18);
    endfunction

    // True for any supported width
    function automatic bit width_ok(input int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || is_parity_w(w);
    endfunction

    // True when a write width and a read width may share the pool
    function automatic bit pair_ok(input int ww, input int rw);
        return width_ok(ww) && width_ok(rw) && (is_parity_w(ww) == is_parity_w(rw));
    endfunction

    // Number of pool bits reachable for a width family
    function automatic int pool_bits(input int w);
        return is_parity_w(w) ? PARITY_POOL : DATA_POOL;
    endfunction
endpackage

// File: rtl/mwram_wr_port.sv
// Write address decoder: turns one word write into a bit mask and
// bit data over the whole pool. Assumes NB is a multiple of WW and
// AW is wide enough to address every word. Addresses with no
// matching word produce an empty mask.
module mwram_wr_port #(
    parameter int WW = 4,
    parameter int AW = 9,
    parameter int NB = 512
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [WW-1:0] wr_data,
    output logic [NB-1:0] wr_mask,
    output logic [NB-1:0] wr_bits
);
    localparam int DEPTH = NB / WW;

    // One lane per word: enable the lane whose index equals the address
    for (genvar g = 0; g < DEPTH; g++) begin : g_lane
        logic hit;
        assign hit                  = wr_en && (wr_addr == AW'(g));
        assign wr_mask[g*WW +: WW]  = {WW{hit}};
        assign wr_bits[g*WW +: WW]  = wr_data;
    end
endmodule

// File: rtl/mwram_store.sv
// Bit-level storage pool. Each bit is written when its mask bit is
// set. Assumes one masked write per cycle and clears on reset.
module mwram_store #(
    parameter int NB = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] wr_mask,
    input  logic [NB-1:0] wr_bits,
    output logic [NB-1:0] cells
);
    // Clear on reset, else merge masked write bits into the pool
    always_ff @(posedge clk) begin
        if (!rst_n) cells <= '0;
        else        cells <= (cells & ~wr_mask) | (wr_bits & wr_mask);
    end
endmodule

// File: rtl/mwram_rd_port.sv
// Read port: splits the pool into RW-bit words, selects one by
// address and registers it. Out-of-range addresses give zero.
// Assumes NB is a multiple of RW. The pool is sampled before
// the same edge's write lands, so a read returns the old data.
module mwram_rd_port #(
    parameter int RW = 16,
    parameter int AW = 9,
    parameter int NB = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [NB-1:0] cells,
    output logic [RW-1:0] rd_data
);
    localparam int          DEPTH   = NB / RW;
    localparam int          IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [RW-1:0] words [DEPTH];
    logic [RW-1:0] pick;

    // Carve the pool into read-width words
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign words[g] = cells[g*RW +: RW];
    end

    // Select the addressed word or zero when past the end
    always_comb begin
        if ({1'b0, rd_addr} < DEPTH_V) pick = words[rd_addr[IDX_W-1:0]];
        else                           pick = '0;
    end

    // Output register loads only when a read is requested
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= pick;
    end
endmodule

// File: rtl/mwram_top.sv
// Mixed-width simple dual-port RAM over a 576-bit pool. Write and read
// widths are parameters; both must come from the same width family.
// Assumes AW covers the deeper of the two ports.
module mwram_top #(
    parameter int WR_W = 4,
    parameter int RD_W = 16,
    parameter int AW   = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    output logic [RD_W-1:0] rd_data
);
    import mwram_pkg::*;

    localparam int NB     = pool_bits(WR_W);
    localparam int WDEPTH = NB / WR_W;
    localparam int RDEPTH = NB / RD_W;
    localparam int MAXD   = (WDEPTH > RDEPTH) ? WDEPTH : RDEPTH;

    // Elaboration guard on the width pairing and address width
    if (!pair_ok(WR_W, RD_W)) begin : g_bad_pair
        $fatal(1, "mwram_top: width pair %0d/%0d not allowed", WR_W, RD_W);
    end
    if ((1 << AW) < MAXD) begin : g_bad_aw
        $fatal(1, "mwram_top: AW=%0d too narrow", AW);
    end

    logic [NB-1:0] wr_mask;
    logic [NB-1:0] wr_bits;
    logic [NB-1:0] cells;

    mwram_wr_port #(.WW(WR_W), .AW(AW), .NB(NB)) u_wr (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .wr_bits (wr_bits)
    );

    mwram_store #(.NB(NB)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_bits (wr_bits),
        .cells   (cells)
    );

    mwram_rd_port #(.RW(RD_W), .AW(AW), .NB(NB)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cells   (cells),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mwram_chk.sv
// Property checker for mwram_top, bound to every instance. It watches
// the ports and the storage pool; it drives nothing.
module mwram_chk #(
    parameter int WR_W = 4,
    parameter int RD_W = 16,
    parameter int AW   = 9,
    parameter int NB   = 512
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [WR_W-1:0] wr_data,
    input logic            rd_en,
    input logic [AW-1:0]   rd_addr,
    input logic [RD_W-1:0] rd_data,
    input logic [NB-1:0]   cells
);
    localparam logic [AW:0] WDEP = (AW+1)'(NB / WR_W);
    localparam logic [AW:0] RDEP = (AW+1)'(NB / RD_W);

    logic            w_in, r_in;
    logic            prev_hit;
    logic [AW-1:0]   prev_addr;
    logic [WR_W-1:0] prev_data;
    logic [WR_W-1:0] prev_slice;
    logic [RD_W-1:0] r_slice;

    assign w_in = {1'b0, wr_addr} < WDEP;
    assign r_in = {1'b0, rd_addr} < RDEP;

    // Pool contents at the last write address, and at the current read address
    assign prev_slice = WR_W'(cells >> (int'(prev_addr) * WR_W));
    assign r_slice    = RD_W'(cells >> (int'(rd_addr) * RD_W));

    // Remember the previous write for the landing check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_hit  <= 1'b0;
            prev_addr <= '0;
            prev_data <= '0;
        end else begin
            prev_hit  <= wr_en && w_in;
            prev_addr <= wr_addr;
            prev_data <= wr_data;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && (cells == '0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_hit |-> (prev_slice == prev_data));

    // R4
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7
    read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && r_in) |=> (rd_data == $past(r_slice)));

    // R8
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !w_in) |=> $stable(cells));

    // R9
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !r_in) |=> (rd_data == '0));
endmodule

bind mwram_top mwram_chk #(.WR_W(WR_W), .RD_W(RD_W), .AW(AW), .NB(NB)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cells   (cells)
);

// File: tb/sim_mwram_top.sv
`timescale 1ns/1ps
module sim_mwram_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // u0: 4-bit write, 16-bit read (plain family)
    logic        we0 = 0, re0 = 0;
    logic [8:0]  wa0 = 0, ra0 = 0;
    logic [3:0]  wd0 = 0;
    logic [15:0] rd0;
    // u1: 18-bit write, 9-bit read (parity family)
    logic        we1 = 0, re1 = 0;
    logic [8:0]  wa1 = 0, ra1 = 0;
    logic [17:0] wd1 = 0;
    logic [8:0]  rd1;

    mwram_top #(.WR_W(4), .RD_W(16), .AW(9)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(we0), .wr_addr(wa0), .wr_data(wd0),
        .rd_en(re0), .rd_addr(ra0), .rd_data(rd0));
    mwram_top #(.WR_W(18), .RD_W(9), .AW(9)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(we1), .wr_addr(wa1), .wr_data(wd1),
        .rd_en(re1), .rd_addr(ra1), .rd_data(rd1));

    int n_cmp = 0, n_bad = 0;
    logic [511:0] m0 = '0;
    logic [575:0] m1 = '0;
    logic [15:0]  e0 = '0;
    logic [8:0]   e1 = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected read of u0 given the model before the edge
    function automatic logic [15:0] exp0(input logic [8:0] a);
        return (a < 32) ? m0[int'(a)*16 +: 16] : 16'h0;
    endfunction
    function automatic logic [8:0] exp1(input logic [8:0] a);
        return (a < 64) ? m1[int'(a)*9 +: 9] : 9'h0;
    endfunction

    // Apply the driven inputs for one edge, update models, compare after it
    task automatic tick(input string tag);
        if (re0) e0 = exp0(ra0);
        if (re1) e1 = exp1(ra1);
        if (we0 && wa0 < 128) m0[int'(wa0)*4 +: 4] = wd0;
        if (we1 && wa1 < 32)  m1[int'(wa1)*18 +: 18] = wd1;
        @(negedge clk);
        chk(tag, 32'(rd0), 32'(e0));
        chk(tag, 32'(rd1), 32'(e1));
        we0 = 0; re0 = 0; we1 = 0; re1 = 0;
    endtask

    function automatic bit ref_pair(input int a, input int b);
        bit pa = (a == 9) || (a == 18);
        bit pb = (b == 9) || (b == 18);
        bit oa = pa || a == 1 || a == 2 || a == 4 || a == 8 || a == 16;
        bit ob = pb || b == 1 || b == 2 || b == 4 || b == 8 || b == 16;
        return oa && ob && (pa == pb);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state at the port
        chk("R1", 32'(rd0), 32'h0);
        chk("R1", 32'(rd1), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        re0 = 1; ra0 = 9'd7; re1 = 1; ra1 = 9'd40; tick("R1");

        // R2 / R5: four nibbles assemble one 16-bit word
        for (int i = 0; i < 4; i++) begin
            we0 = 1; wa0 = 9'(i); wd0 = 4'(i + 1); tick("R2");
        end
        re0 = 1; ra0 = 9'd0; tick("R5");
        chk("R5", 32'(rd0), 32'h4321);
        // R5: top in-range nibble lands in the top nibble of word 31
        we0 = 1; wa0 = 9'd127; wd0 = 4'hA; tick("R2");
        re0 = 1; ra0 = 9'd31; tick("R5");
        chk("R5", 32'(rd0), 32'hA000);

        // R3: output does not move before the edge
        re0 = 1; ra0 = 9'd0;
        #2 chk("R3", 32'(rd0), 32'hA000);
        tick("R3");
        chk("R3", 32'(rd0), 32'h4321);

        // R4: read disabled, storage changes, output holds
        we0 = 1; wa0 = 9'd1; wd0 = 4'hF; tick("R4");
        tick("R4");
        chk("R4", 32'(rd0), 32'h4321);

        // R7: same-address read and write return old data
        we0 = 1; wa0 = 9'd1; wd0 = 4'h6; re0 = 1; ra0 = 9'd0; tick("R7");
        chk("R7", 32'(rd0), 32'h43F1);
        re0 = 1; ra0 = 9'd0; tick("R7");
        chk("R7", 32'(rd0), 32'h4361);

        // R6: 18-bit write at 3 reads back as bytes 6 (low) and 7 (high)
        we1 = 1; wa1 = 9'd3; wd1 = 18'h2A5C3; tick("R6");
        re1 = 1; ra1 = 9'd6; tick("R6");
        chk("R6", 32'(rd1), 32'h1C3);
        re1 = 1; ra1 = 9'd7; tick("R6");
        chk("R6", 32'(rd1), 32'h152);
        we1 = 1; wa1 = 9'd31; wd1 = 18'h3FE01; tick("R6");
        re1 = 1; ra1 = 9'd63; tick("R6");
        chk("R6", 32'(rd1), 32'h1FF);

        // R8: writes just past the end must not alias onto word 0
        we0 = 1; wa0 = 9'd128; wd0 = 4'h0; we1 = 1; wa1 = 9'd32; wd1 = 18'h3FFFF; tick("R8");
        we0 = 1; wa0 = 9'd511; wd0 = 4'h0; tick("R8");
        re0 = 1; ra0 = 9'd0; re1 = 1; ra1 = 9'd0; tick("R8");
        chk("R8", 32'(rd0), 32'h4361);
        chk("R8", 32'(rd1), 32'h0);

        // R9: reads past the end give zero
        re0 = 1; ra0 = 9'd32; re1 = 1; ra1 = 9'd64; tick("R9");
        chk("R9", 32'(rd0), 32'h0);
        chk("R9", 32'(rd1), 32'h0);

        // R10: width pairing rule agrees with the package
        chk("R10", 32'(mwram_pkg::pair_ok(4, 16)), 32'(ref_pair(4, 16)));
        chk("R10", 32'(mwram_pkg::pair_ok(9, 18)), 32'(ref_pair(9, 18)));
        chk("R10", 32'(mwram_pkg::pair_ok(8, 9)),  32'(ref_pair(8, 9)));
        chk("R10", 32'(mwram_pkg::pair_ok(18, 1)), 32'(ref_pair(18, 1)));
        chk("R10", 32'(mwram_pkg::pair_ok(3, 3)),  32'(ref_pair(3, 3)));

        // R2: random mix, biased so most addresses are in range
        for (int i = 0; i < 4000; i++) begin
            we0 = 1'($urandom); re0 = 1'($urandom);
            wa0 = ($urandom % 8 == 0) ? 9'($urandom) : 9'($urandom % 128);
            ra0 = ($urandom % 8 == 0) ? 9'($urandom) : 9'($urandom % 32);
            wd0 = 4'($urandom);
            we1 = 1'($urandom); re1 = 1'($urandom);
            wa1 = ($urandom % 8 == 0) ? 9'($urandom) : 9'($urandom % 32);
            ra1 = ($urandom % 8 == 0) ? 9'($urandom) : 9'($urandom % 64);
            wd1 = 18'($urandom);
            tick("R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is one failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule